// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches a 64-bit system count supplied from outside and expects software to check in before a programmed deadline passes. If the count reaches the deadline once, the block raises an interrupt level and sets a new deadline one timeout period later. If the count reaches that second deadline before software checks in, the block raises a reset-request level. Software checks in by writing to a one-register refresh window. All setup goes through a separate control window.

The timeout period is 48 bits wide. Its low word and its upper 16 bits sit in two registers. Writing either half, or checking in, loads the deadline with the current count plus the period. Software can also read and overwrite the 64-bit deadline directly. Each window is a plain 32-bit register port with an access strobe, a write flag, a 12-bit byte address and data lines. Reads are combinational.

Top module: `wdog2s_top`

## Requirements
- R1: After reset the enable bit, both stage flags, the period and the deadline are all zero, and both `irq_o` and `rst_req_o` are low.
- R2: A control-window read at 0xFCC returns 0x0001043B. A refresh-window read returns zero and changes no state.
- R3: The control word at 0x000 has enable at bit 0, the first-stage flag at bit 1 and the second-stage flag at bit 2. Only bit 0 is writable. Writing 0 to bit 0 clears both flags in the next cycle. While disabled, no flag is ever set.
- R4: The period low word is at 0x008 and the period upper 16 bits are at 0x00C. Bits 31:16 of a 0x00C write are dropped and read back as zero. A 0x008 write zeroes the upper period bits. A write to either address loads the deadline with the count sampled in that cycle plus the new period.
- R5: The deadline low word at 0x010 and high word at 0x014 are read/write. A direct write replaces only that half and leaves both flags unchanged.
- R6: When enabled with the first-stage flag clear and count >= deadline, the next cycle has the first-stage flag set, `irq_o` high, and the deadline equal to that count plus the period.
- R7: When enabled with the first-stage flag set and count >= deadline, the next cycle has the second-stage flag set and `rst_req_o` high.
- R8: A write of any data to refresh-window address 0x000 clears both flags and loads the deadline with count plus period. If an expiry falls in the same cycle, the refresh takes priority.
- R9: A control-window access to an unmapped or non-word-aligned address reads zero and its write changes nothing.
- R10: `irq_o` always equals the first-stage flag and `rst_req_o` always equals the second-stage flag, as read back in the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_count | input | 64 | Free-running system count |
| rf_en | input | 1 | Refresh-window access strobe |
| rf_we | input | 1 | Refresh-window write flag |
| rf_addr | input | 12 | Refresh-window byte address |
| rf_wdata | input | 32 | Refresh-window write data (value ignored) |
| rf_rdata | output | 32 | Refresh-window read data (always zero) |
| cf_en | input | 1 | Control-window access strobe |
| cf_we | input | 1 | Control-window write flag |
| cf_addr | input | 12 | Control-window byte address |
| cf_wdata | input | 32 | Control-window write data |
| cf_rdata | output | 32 | Control-window read data |
| irq_o | output | 1 | First-stage interrupt level |
| rst_req_o | output | 1 | Second-stage reset-request level |

## Verification
The collisions that matter are a software check-in, or a disable write, landing in the same cycle as a deadline hit. The bench provokes them by setting the deadline low word to exactly the count that the following access cycle will sample, and then issuing the refresh or disable in that cycle. It judges the outcome by requiring `irq_o` to stay low afterwards, and after the refresh case it also requires the deadline to be reloaded from the refresh cycle's count. A reference model in the bench, updated every clock, compares both output levels and every read value on every cycle.

// File: rtl/wdog2s_pkg.sv
`timescale 1ns/1ps
package wdog2s_pkg;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 12;
  localparam int CNT_W    = 64;
  localparam int OFF_W    = 48;
  localparam int OFF_HI_W = OFF_W - REG_W;

  // control window map
  localparam logic [ADDR_W-1:0] A_CTRL    = 12'h000;
  localparam logic [ADDR_W-1:0] A_OFS_LO  = 12'h008;
  localparam logic [ADDR_W-1:0] A_OFS_HI  = 12'h00C;
  localparam logic [ADDR_W-1:0] A_CMP_LO  = 12'h010;
  localparam logic [ADDR_W-1:0] A_CMP_HI  = 12'h014;
  localparam logic [ADDR_W-1:0] A_IDENT   = 12'hFCC;
  // refresh window map
  localparam logic [ADDR_W-1:0] A_REFRESH = 12'h000;

  localparam logic [REG_W-1:0] IDENT_VAL = 32'h0001_043B;

  localparam int BIT_EN = 0;
  localparam int BIT_S1 = 1;
  localparam int BIT_S2 = 2;

  typedef struct packed {
    logic refresh;
    logic ctrl;
    logic ofs_lo;
    logic ofs_hi;
    logic cmp_lo;
    logic cmp_hi;
  } wr_t;

  // deadline = sampled count + zero-extended period
  function automatic logic [CNT_W-1:0] deadline(input logic [CNT_W-1:0] now,
                                                input logic [OFF_HI_W-1:0] hi,
                                                input logic [REG_W-1:0] lo);
    return now + CNT_W'({hi, lo});
  endfunction

  function automatic logic [REG_W-1:0] status_word(input logic en,
                                                   input logic s1,
                                                   input logic s2);
    logic [REG_W-1:0] w;
    w         = '0;
    w[BIT_EN] = en;
    w[BIT_S1] = s1;
    w[BIT_S2] = s2;
    return w;
  endfunction
endpackage

// File: rtl/wdog2s_decode.sv
`timescale 1ns/1ps
module wdog2s_decode
  import wdog2s_pkg::*;
(
  input  logic              cf_en,
  input  logic              cf_we,
  input  logic [ADDR_W-1:0] cf_addr,
  input  logic              rf_en,
  input  logic              rf_we,
  input  logic [ADDR_W-1:0] rf_addr,
  output wr_t               wr
);
  logic cw;
  assign cw = cf_en & cf_we;

  // exact address match: misaligned or unmapped writes hit nothing
  always_comb begin
    wr.ctrl    = cw & (cf_addr == A_CTRL);
    wr.ofs_lo  = cw & (cf_addr == A_OFS_LO);
    wr.ofs_hi  = cw & (cf_addr == A_OFS_HI);
    wr.cmp_lo  = cw & (cf_addr == A_CMP_LO);
    wr.cmp_hi  = cw & (cf_addr == A_CMP_HI);
    wr.refresh = rf_en & rf_we & (rf_addr == A_REFRESH);
  end
endmodule

// File: rtl/wdog2s_deadline.sv
`timescale 1ns/1ps
module wdog2s_deadline
  import wdog2s_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  wr_t                 wr,
  input  logic [REG_W-1:0]    wdata,
  input  logic [CNT_W-1:0]    count,
  input  logic                fire1,
  output logic [REG_W-1:0]    ofs_lo,
  output logic [OFF_HI_W-1:0] ofs_hi,
  output logic [CNT_W-1:0]    cmp,
  output logic                due
);
  logic [REG_W-1:0]    lo_n;
  logic [OFF_HI_W-1:0] hi_n;
  logic [CNT_W-1:0]    cmp_n;
  logic                reload;

  assign due    = (count >= cmp);
  assign reload = wr.refresh | wr.ofs_lo | wr.ofs_hi | fire1;

  always_comb begin
    lo_n = wr.ofs_lo ? wdata : ofs_lo;
    if (wr.ofs_lo)      hi_n = '0;
    else if (wr.ofs_hi) hi_n = wdata[OFF_HI_W-1:0];
    else                hi_n = ofs_hi;

    cmp_n = reload ? deadline(count, hi_n, lo_n) : cmp;
    // a direct write of one half wins over any reload in the same cycle
    if (wr.cmp_lo) cmp_n[REG_W-1:0]     = wdata;
    if (wr.cmp_hi) cmp_n[CNT_W-1:REG_W] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_lo <= '0;
      ofs_hi <= '0;
      cmp    <= '0;
    end else begin
      ofs_lo <= lo_n;
      ofs_hi <= hi_n;
      cmp    <= cmp_n;
    end
  end
endmodule

// File: rtl/wdog2s_stages.sv
`timescale 1ns/1ps
module wdog2s_stages
  import wdog2s_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  wr_t  wr,
  input  logic en_bit,
  input  logic due,
  output logic en,
  output logic ws0,
  output logic ws1,
  output logic hit,
  output logic fire1,
  output logic fire2
);
  logic kill;

  // refresh or a disable write wins over an expiry in the same cycle
  assign kill  = wr.refresh | (wr.ctrl & ~en_bit);
  assign hit   = en & due;
  assign fire1 = hit & ~ws0 & ~kill;
  assign fire2 = hit & ws0 & ~ws1 & ~kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      ws0 <= 1'b0;
      ws1 <= 1'b0;
    end else begin
      if (wr.ctrl) en <= en_bit;
      ws0 <= kill ? 1'b0 : (ws0 | fire1);
      ws1 <= kill ? 1'b0 : (ws1 | fire2);
    end
  end
endmodule

// File: rtl/wdog2s_top.sv
`timescale 1ns/1ps
module wdog2s_top
  import wdog2s_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  sys_count,
  input  logic              rf_en,
  input  logic              rf_we,
  input  logic [ADDR_W-1:0] rf_addr,
  input  logic [REG_W-1:0]  rf_wdata,
  output logic [REG_W-1:0]  rf_rdata,
  input  logic              cf_en,
  input  logic              cf_we,
  input  logic [ADDR_W-1:0] cf_addr,
  input  logic [REG_W-1:0]  cf_wdata,
  output logic [REG_W-1:0]  cf_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  wr_t                 wr_w;
  logic                en_w, ws0_w, ws1_w, hit_w, fire1_w, fire2_w, due_w;
  logic [REG_W-1:0]    off_lo_w;
  logic [OFF_HI_W-1:0] off_hi_w;
  logic [CNT_W-1:0]    cmp_w;
  logic                unused_rf;

  // refresh data value carries no meaning
  assign unused_rf = ^rf_wdata;

  wdog2s_decode u_dec (
    .cf_en  (cf_en),
    .cf_we  (cf_we),
    .cf_addr(cf_addr),
    .rf_en  (rf_en),
    .rf_we  (rf_we),
    .rf_addr(rf_addr),
    .wr     (wr_w)
  );

  wdog2s_stages u_stg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_w),
    .en_bit(cf_wdata[BIT_EN]),
    .due   (due_w),
    .en    (en_w),
    .ws0   (ws0_w),
    .ws1   (ws1_w),
    .hit   (hit_w),
    .fire1 (fire1_w),
    .fire2 (fire2_w)
  );

  wdog2s_deadline u_dl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_w),
    .wdata (cf_wdata),
    .count (sys_count),
    .fire1 (fire1_w),
    .ofs_lo(off_lo_w),
    .ofs_hi(off_hi_w),
    .cmp   (cmp_w),
    .due   (due_w)
  );

  assign irq_o     = ws0_w;
  assign rst_req_o = ws1_w;
  assign rf_rdata  = '0;

  always_comb begin
    cf_rdata = '0;
    if (cf_en && !cf_we) begin
      case (cf_addr)
        A_CTRL:   cf_rdata = status_word(en_w, ws0_w, ws1_w);
        A_OFS_LO: cf_rdata = off_lo_w;
        A_OFS_HI: cf_rdata = REG_W'(off_hi_w);
        A_CMP_LO: cf_rdata = cmp_w[REG_W-1:0];
        A_CMP_HI: cf_rdata = cmp_w[CNT_W-1:REG_W];
        A_IDENT:  cf_rdata = IDENT_VAL;
        default:  cf_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog2s_chk.sv
`timescale 1ns/1ps
module wdog2s_chk
  import wdog2s_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [CNT_W-1:0]    sys_count,
  input logic                rf_en,
  input logic                rf_we,
  input logic [ADDR_W-1:0]   rf_addr,
  input logic                cf_en,
  input logic                cf_we,
  input logic [ADDR_W-1:0]   cf_addr,
  input logic [REG_W-1:0]    cf_rdata,
  input logic                irq_o,
  input logic                rst_req_o,
  input logic                en_w,
  input logic                hit_w,
  input logic [CNT_W-1:0]    cmp_w,
  input logic [REG_W-1:0]    off_lo_w,
  input logic [OFF_HI_W-1:0] off_hi_w
);
  a_r6_irq_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(hit_w));

  a_r6_fire_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o) && !$past(cf_en && cf_we && (cf_addr == A_CMP_LO || cf_addr == A_CMP_HI)))
      |-> (cmp_w == $past(sys_count) + CNT_W'({off_hi_w, off_lo_w})));

  a_r7_reset_after_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> $past(irq_o));

  a_r8_refresh_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_en && rf_we && rf_addr == A_REFRESH) |=> (!irq_o && !rst_req_o));

  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_w |-> (!irq_o && !rst_req_o));

  a_r4_low_zeroes_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_en && cf_we && cf_addr == A_OFS_LO) |=> (off_hi_w == '0));

  a_r2_ident_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_en && !cf_we && cf_addr == A_IDENT) |-> (cf_rdata == IDENT_VAL));
endmodule

bind wdog2s_top wdog2s_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sys_count(sys_count),
  .rf_en    (rf_en),
  .rf_we    (rf_we),
  .rf_addr  (rf_addr),
  .cf_en    (cf_en),
  .cf_we    (cf_we),
  .cf_addr  (cf_addr),
  .cf_rdata (cf_rdata),
  .irq_o    (irq_o),
  .rst_req_o(rst_req_o),
  .en_w     (en_w),
  .hit_w    (hit_w),
  .cmp_w    (cmp_w),
  .off_lo_w (off_lo_w),
  .off_hi_w (off_hi_w)
);

// File: tb/wdog2s_top_test.sv
`timescale 1ns/1ps
module wdog2s_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_count = 64'h100;
  logic        rf_en = 0, rf_we = 0, cf_en = 0, cf_we = 0;
  logic [11:0] rf_addr = '0, cf_addr = '0;
  logic [31:0] rf_wdata = '0, cf_wdata = '0;
  logic [31:0] rf_rdata, cf_rdata;
  logic        irq_o, rst_req_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #2.5 clk = ~clk;

  wdog2s_top uut (
    .clk(clk), .rst_n(rst_n), .sys_count(sys_count),
    .rf_en(rf_en), .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .cf_en(cf_en), .cf_we(cf_we), .cf_addr(cf_addr), .cf_wdata(cf_wdata), .cf_rdata(cf_rdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  // ---------------- reference model ----------------
  bit          m_en, m_s1, m_s2;
  logic [31:0] m_lo;
  logic [15:0] m_hi;
  logic [63:0] m_dl;

  always @(posedge clk) begin : model
    bit          wc, wr, kill, due, f1, f2, nen, ns1, ns2;
    logic [31:0] nlo;
    logic [15:0] nhi;
    logic [63:0] ndl;
    if (!rst_n) begin
      m_en = 0; m_s1 = 0; m_s2 = 0; m_lo = 0; m_hi = 0; m_dl = 0;
    end else begin
      wc   = cf_en && cf_we;
      wr   = rf_en && rf_we && rf_addr == 12'h000;
      kill = wr || (wc && cf_addr == 12'h000 && !cf_wdata[0]);
      due  = m_en && (sys_count >= m_dl);
      f1 = 0; f2 = 0;
      if (due && !kill) begin
        if (!m_s1) f1 = 1; else f2 = 1;
      end
      nen = m_en; ns1 = m_s1 | f1; ns2 = m_s2 | f2;
      if (wc && cf_addr == 12'h000) nen = cf_wdata[0];
      if (kill) begin ns1 = 0; ns2 = 0; end
      nlo = m_lo; nhi = m_hi; ndl = m_dl;
      if (wc && cf_addr == 12'h008) begin nlo = cf_wdata; nhi = 0; end
      if (wc && cf_addr == 12'h00C) nhi = cf_wdata[15:0];
      if (wr || f1 || (wc && (cf_addr == 12'h008 || cf_addr == 12'h00C)))
        ndl = sys_count + {16'h0, nhi, nlo};
      if (wc && cf_addr == 12'h010) ndl[31:0]  = cf_wdata;
      if (wc && cf_addr == 12'h014) ndl[63:32] = cf_wdata;
      m_en = nen; m_s1 = ns1; m_s2 = ns2; m_lo = nlo; m_hi = nhi; m_dl = ndl;
    end
  end

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h000: return {29'h0, m_s2, m_s1, m_en};
      12'h008: return m_lo;
      12'h00C: return {16'h0, m_hi};
      12'h010: return m_dl[31:0];
      12'h014: return m_dl[63:32];
      12'hFCC: return 32'h0001043B;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    case (a)
      12'h000: return "R3 ctrl read";
      12'h008, 12'h00C: return "R4 period read";
      12'h010, 12'h014: return "R5 deadline read";
      12'hFCC: return "R2 ident read";
      default: return "R9 unmapped read";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk(irq_o === m_s1, "R10 irq level", {63'h0, irq_o}, {63'h0, m_s1});
      chk(rst_req_o === m_s2, "R10 reset-request level", {63'h0, rst_req_o}, {63'h0, m_s2});
      if (cf_en && !cf_we)
        chk(cf_rdata === m_read(cf_addr), tag_of(cf_addr), {32'h0, cf_rdata}, {32'h0, m_read(cf_addr)});
      if (rf_en && !rf_we)
        chk(rf_rdata === 32'h0, "R2 refresh read", {32'h0, rf_rdata}, 64'h0);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk);
    #1;
    cf_en = 0; cf_we = 0; rf_en = 0; rf_we = 0;
    sys_count = sys_count + 1;
  endtask

  task automatic cwr(input logic [11:0] a, input logic [31:0] d);
    cf_en = 1; cf_we = 1; cf_addr = a; cf_wdata = d;
    tick();
  endtask

  task automatic crd(input logic [11:0] a, output logic [31:0] d);
    cf_en = 1; cf_we = 0; cf_addr = a;
    #1 d = cf_rdata;
    tick();
  endtask

  task automatic rwr(input logic [31:0] d);
    rf_en = 1; rf_we = 1; rf_addr = 12'h000; rf_wdata = d;
    tick();
  endtask

  task automatic rrd();
    rf_en = 1; rf_we = 0; rf_addr = 12'h000;
    tick();
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "watchdog expired", 64'h0, 64'h1);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [63:0] c;
    repeat (3) tick();
    rst_n = 1;
    tick();

    // R1 reset state
    chk(irq_o === 0 && rst_req_o === 0, "R1 outputs low", {62'h0, irq_o, rst_req_o}, 64'h0);
    crd(12'h000, d); chk(d === 0, "R1 ctrl zero", {32'h0, d}, 0);
    crd(12'h008, d); chk(d === 0, "R1 period zero", {32'h0, d}, 0);
    crd(12'h014, d); chk(d === 0, "R1 deadline zero", {32'h0, d}, 0);

    // R2 ident and refresh read
    crd(12'hFCC, d); chk(d === 32'h0001043B, "R2 ident", {32'h0, d}, 64'h0001043B);
    rrd();
    crd(12'h000, d); chk(d === 0, "R2 refresh read no effect", {32'h0, d}, 0);

    // R4 upper period
    c = sys_count;
    cwr(12'h00C, 32'hABCD_1234);
    crd(12'h00C, d); chk(d === 32'h1234, "R4 upper bits masked", {32'h0, d}, 64'h1234);
    crd(12'h014, d); c = c + 64'h1234_0000_0000;
    chk(d === c[63:32], "R4 reload from upper write", {32'h0, d}, {32'h0, c[63:32]});
    c = sys_count;
    cwr(12'h008, 32'd20);
    crd(12'h00C, d); chk(d === 0, "R4 low write zeroes upper", {32'h0, d}, 0);
    crd(12'h010, d); c = c + 20;
    chk(d === c[31:0], "R4 reload from low write", {32'h0, d}, {32'h0, c[31:0]});

    // R6 first stage, R7 second stage, R10 readback
    cwr(12'h000, 32'h1);
    for (int i = 0; i < 60 && !irq_o; i++) tick();
    chk(irq_o === 1, "R6 interrupt raised", {63'h0, irq_o}, 1);
    crd(12'h000, d); chk(d === 32'h3, "R10 ctrl shows first stage", {32'h0, d}, 3);
    for (int i = 0; i < 60 && !rst_req_o; i++) tick();
    chk(rst_req_o === 1, "R7 reset request raised", {63'h0, rst_req_o}, 1);
    crd(12'h000, d); chk(d === 32'h7, "R7 ctrl shows both stages", {32'h0, d}, 7);

    // R8 refresh
    c = sys_count;
    rwr(32'hDEAD_BEEF);
    chk(irq_o === 0 && rst_req_o === 0, "R8 refresh clears", {62'h0, irq_o, rst_req_o}, 0);
    crd(12'h010, d); c = c + 20;
    chk(d === c[31:0], "R8 refresh reloads", {32'h0, d}, {32'h0, c[31:0]});

    // R5 direct deadline write keeps flags
    for (int i = 0; i < 60 && !irq_o; i++) tick();
    cwr(12'h014, 32'h1);
    cwr(12'h010, 32'h0);
    crd(12'h000, d); chk(d === 32'h3, "R5 flags unchanged by deadline write", {32'h0, d}, 3);
    crd(12'h014, d); chk(d === 32'h1, "R5 deadline high written", {32'h0, d}, 1);

    // R3 disable
    cwr(12'h000, 32'h0);
    chk(irq_o === 0, "R3 disable clears flags", {63'h0, irq_o}, 0);
    cwr(12'h014, 32'h0);
    cwr(12'h010, 32'h0);
    repeat (10) tick();
    chk(irq_o === 0 && rst_req_o === 0, "R3 no expiry while disabled", {62'h0, irq_o, rst_req_o}, 0);
    cwr(12'h000, 32'h6);
    crd(12'h000, d); chk(d === 0, "R3 flag bits read-only", {32'h0, d}, 0);

    // R9 misaligned / unmapped
    cwr(12'h009, 32'hFFFF_FFFF);
    cwr(12'h020, 32'hFFFF_FFFF);
    crd(12'h008, d); chk(d === 32'd20, "R9 misaligned write ignored", {32'h0, d}, 20);
    crd(12'h020, d); chk(d === 0, "R9 unmapped read zero", {32'h0, d}, 0);
    crd(12'h00A, d); chk(d === 0, "R9 misaligned read zero", {32'h0, d}, 0);

    // R8 collision: refresh in the cycle the deadline is hit
    cwr(12'h008, 32'd1000);
    cwr(12'h000, 32'h1);
    c = sys_count;
    cwr(12'h010, c[31:0] + 32'd1);
    c = sys_count;
    rwr(32'h0);
    chk(irq_o === 0, "R8 refresh beats same-cycle expiry", {63'h0, irq_o}, 0);
    crd(12'h010, d); c = c + 1000;
    chk(d === c[31:0], "R8 collision reload", {32'h0, d}, {32'h0, c[31:0]});
    tick();
    chk(irq_o === 0, "R8 no late interrupt", {63'h0, irq_o}, 0);

    // R3 collision: disable in the cycle the deadline is hit
    c = sys_count;
    cwr(12'h010, c[31:0] + 32'd1);
    cwr(12'h000, 32'h0);
    chk(irq_o === 0, "R3 disable beats same-cycle expiry", {63'h0, irq_o}, 0);
    repeat (3) tick();

    finish_run();
  end
endmodule